// File: doc/BRIEF.md
# Subscriber Line Layer-1 Activation Controller

This block runs the terminal-side activation and deactivation procedure of a basic-rate subscriber line. It watches the 4-bit indication codes that the line interface reports through its status register. It also takes single-cycle activate and deactivate requests from the layer above. From these it works out the layer-1 state and answers with 4-bit command codes, each marked by a one-cycle strobe, that are to be written back to the line interface. It also raises one-cycle pulses when layer 1 becomes active and when it drops out of service.

The states follow the line standard's F-state naming. There are nine, encoded as a 4-bit value: 0 reset, 1 F3 power-down, 2 F3 power-up, 3 F3 pending-deactivation, 4 F4, 5 F5, 6 F6, 7 F7 (active) and 8 F8. The transition table is sparse. Any pairing of state and event that is not listed is ignored. An activation supervision timer is started by an activate request in F3 power-down and is cancelled when F7 is reached. If it runs out, the upper layer is told that activation failed.

The named transitions are:
- reset-by-line (RES/EI)
- activate-complete (AI8 to F7)
- activate-request (in F3 power-down)
- supervision-expiry
- power-down (DC)
- activate-seen (AR to F6)
- resync (RSY to F5/F8)
- power-up (PU to F4)
- deactivate-seen (DR/DR6 to F3 pending-deactivation)
- the three F7 exits

Top module: `l1_act_ctrl`

## Requirements
- R1: After the hardware reset (`rst_n` low), `state_o` is 0 (reset), and `cmd_valid`, `act_ind` and `deact_ind` are low. State encoding: 0 reset, 1 F3 power-down, 2 F3 power-up, 3 F3 pending-deactivation, 4 F4, 5 F5, 6 F6, 7 F7, 8 F8.
- R2: Indication RES (0001) or EI (0110) moves the machine to reset and issues command DI (1111) from reset, F3 power-down, F3 pending-deactivation, F4, F5, F6, F8 and F7. From F7 it also pulses `deact_ind`.
- R3: Indication AI8 (1100) moves the machine to F7 from every state except F3 power-up and F7. It issues command AR8 (1000), pulses `act_ind` and cancels the supervision timer, so no later expiry is reported.
- R4: An activate request in F3 power-down issues AR8 (1000) and reloads the supervision timer, and the state does not change. In every other state the request is ignored.
- R5: When the timer is started at clock edge N, it expires at edge N+TIMER_CYCLES. If the state is then F3 power-down, F4, F5, F6 or F8, the machine issues DI (1111) and pulses `deact_ind`, and the state does not change. The timer then stops.
- R6: Indication DC (1111) moves the machine to F3 power-down from reset, F3 pending-deactivation, F4, F5, F6 and F8. Indication PU (0111) moves it from F3 power-down to F4.
- R7: Indication AR (1000) moves the machine to F6 from reset, F3 power-down, F3 pending-deactivation, F5 and F8. Indication RSY (0100) moves it to F5 from F3 power-down, F3 pending-deactivation and F4, and moves it from F6 to F8.
- R8: Indication DR (0000) in F5 or F8, or DR6 (0101) in F6, moves the machine to F3 pending-deactivation and issues DI (1111).
- R9: In F7, AR goes to F6, RSY goes to F8, and DR goes to F3 pending-deactivation with DI issued. Each of these three moves pulses `deact_ind`.
- R10: Deactivate requests, indication codes outside the table (such as 0010 or 1001) and unlisted pairings of state and event leave `state_o` unchanged, keep `cmd_valid`, `act_ind` and `deact_ind` low, and keep `cmd_code` unchanged. `act_ind` and `deact_ind` are never high together or on two cycles in a row.
- R11: Only one event is taken per cycle. An indication beats an activate request, which beats a deactivate request, which beats a timer expiry. The losing event is dropped.
- R12: All outputs are registered. The reaction to an event sampled at a clock edge appears right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_valid | input | 1 | New indication code present this cycle |
| ind_code | input | 4 | Indication code from the line interface |
| act_req | input | 1 | Single-cycle activate request from upper layer |
| deact_req | input | 1 | Single-cycle deactivate request from upper layer |
| cmd_valid | output | 1 | One-cycle strobe: `cmd_code` is to be written to the line interface |
| cmd_code | output | 4 | Command code (1000 AR8, 1111 DI) |
| act_ind | output | 1 | Pulse: layer 1 became active |
| deact_ind | output | 1 | Pulse: layer 1 deactivated or activation failed |
| state_o | output | 4 | Current state |

## Verification
The bound checker watches several properties on every cycle:
- the F7 entry and exit pulses line up with the state change;
- reset is only entered with a DI command;
- F4 is only reached from F3 power-down;
- only AR8 and DI are ever strobed;
- the two indication pulses never coincide or repeat.

Other behaviour needs the bench's scenarios. This covers the exact cycle on which the supervision timer expires and whether a cancelled timer stays silent. It also covers event priority when inputs collide, and whether unlisted codes truly leave everything untouched. These are shown by comparing every cycle against the bench's behavioural model.

// File: rtl/l1_act_pkg.sv
package l1_act_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_F3_PDN  = 4'd1,
        ST_F3_PUP  = 4'd2,
        ST_F3_PEND = 4'd3,
        ST_F4      = 4'd4,
        ST_F5      = 4'd5,
        ST_F6      = 4'd6,
        ST_F7      = 4'd7,
        ST_F8      = 4'd8
    } l1_state_e;

    // indication codes from the line interface
    localparam logic [3:0] IND_DEACT_REQ  = 4'b0000;
    localparam logic [3:0] IND_LINE_RESET = 4'b0001;
    localparam logic [3:0] IND_TEST_MODE  = 4'b0010;
    localparam logic [3:0] IND_SLIP       = 4'b0011;
    localparam logic [3:0] IND_RESYNC     = 4'b0100;
    localparam logic [3:0] IND_DEACT_F6   = 4'b0101;
    localparam logic [3:0] IND_ERROR      = 4'b0110;
    localparam logic [3:0] IND_POWER_UP   = 4'b0111;
    localparam logic [3:0] IND_ACT_SEEN   = 4'b1000;
    localparam logic [3:0] IND_ACT_LOOP   = 4'b1010;
    localparam logic [3:0] IND_CODE_VIOL  = 4'b1011;
    localparam logic [3:0] IND_ACTIVE8    = 4'b1100;
    localparam logic [3:0] IND_ACTIVE10   = 4'b1101;
    localparam logic [3:0] IND_ACTIVE_LP  = 4'b1110;
    localparam logic [3:0] IND_DEACT_CONF = 4'b1111;

    // command codes toward the line interface
    localparam logic [3:0] CMD_TIMING     = 4'h0;
    localparam logic [3:0] CMD_RESET      = 4'h1;
    localparam logic [3:0] CMD_PULSE_ONE  = 4'h2;
    localparam logic [3:0] CMD_PULSE_CONT = 4'h3;
    localparam logic [3:0] CMD_ACT8       = 4'h8;
    localparam logic [3:0] CMD_ACT10      = 4'h9;
    localparam logic [3:0] CMD_ACT_LOOP   = 4'hA;
    localparam logic [3:0] CMD_DEACT      = 4'hF;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_IND,
        EV_ACT,
        EV_DEACT,
        EV_TMR
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e   kind;
        logic [3:0] code;
    } l1_event_t;

endpackage

// File: rtl/l1_event_arb.sv
module l1_event_arb
    import l1_act_pkg::*;
(
    input  logic       ind_valid,
    input  logic [3:0] ind_code,
    input  logic       act_req,
    input  logic       deact_req,
    input  logic       tmr_expire,
    output l1_event_t  ev
);
    // fixed priority: indication, activate, deactivate, timer
    always_comb begin
        ev.code = ind_code;
        if (ind_valid)       ev.kind = EV_IND;
        else if (act_req)    ev.kind = EV_ACT;
        else if (deact_req)  ev.kind = EV_DEACT;
        else if (tmr_expire) ev.kind = EV_TMR;
        else                 ev.kind = EV_NONE;
    end
endmodule

// File: rtl/l1_sup_timer.sv
module l1_sup_timer #(
    parameter int RELOAD = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    output logic expire
);
    localparam int CW = $clog2(RELOAD + 1);
    localparam logic [CW-1:0] RELOAD_V = CW'(RELOAD);
    localparam logic [CW-1:0] ONE_V    = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign expire = run_q && (cnt_q == ONE_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            cnt_q <= RELOAD_V;
            run_q <= 1'b1;
        end else if (cancel) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == ONE_V) run_q <= 1'b0;
            else                cnt_q <= cnt_q - ONE_V;
        end
    end
endmodule

// File: rtl/l1_act_fsm.sv
module l1_act_fsm
    import l1_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  l1_event_t  ev,
    output logic       tmr_start,
    output logic       tmr_cancel,
    output logic       cmd_valid,
    output logic [3:0] cmd_code,
    output logic       act_ind,
    output logic       deact_ind,
    output l1_state_e  state
);
    l1_state_e  st_q, st_d;
    logic       cv_d, act_d, deact_d;
    logic [3:0] cc_d;

    always_comb begin
        st_d       = st_q;
        cv_d       = 1'b0;
        cc_d       = CMD_DEACT;
        act_d      = 1'b0;
        deact_d    = 1'b0;
        tmr_start  = 1'b0;
        tmr_cancel = 1'b0;
        unique case (ev.kind)
            EV_IND: begin
                case (ev.code)
                    IND_LINE_RESET, IND_ERROR: begin
                        if (st_q != ST_F3_PUP) begin
                            st_d    = ST_RESET;
                            cv_d    = 1'b1;
                            cc_d    = CMD_DEACT;
                            deact_d = (st_q == ST_F7);
                        end
                    end
                    IND_ACTIVE8: begin
                        if (st_q != ST_F3_PUP && st_q != ST_F7) begin
                            st_d       = ST_F7;
                            cv_d       = 1'b1;
                            cc_d       = CMD_ACT8;
                            act_d      = 1'b1;
                            tmr_cancel = 1'b1;
                        end
                    end
                    IND_DEACT_CONF: begin
                        if (st_q inside {ST_RESET, ST_F3_PEND, ST_F4, ST_F5, ST_F6, ST_F8})
                            st_d = ST_F3_PDN;
                    end
                    IND_ACT_SEEN: begin
                        if (st_q inside {ST_RESET, ST_F3_PDN, ST_F3_PEND, ST_F5, ST_F8}) begin
                            st_d = ST_F6;
                        end else if (st_q == ST_F7) begin
                            st_d    = ST_F6;
                            deact_d = 1'b1;
                        end
                    end
                    IND_RESYNC: begin
                        if (st_q inside {ST_F3_PDN, ST_F3_PEND, ST_F4}) begin
                            st_d = ST_F5;
                        end else if (st_q == ST_F6) begin
                            st_d = ST_F8;
                        end else if (st_q == ST_F7) begin
                            st_d    = ST_F8;
                            deact_d = 1'b1;
                        end
                    end
                    IND_POWER_UP: begin
                        if (st_q == ST_F3_PDN) st_d = ST_F4;
                    end
                    IND_DEACT_REQ: begin
                        if (st_q inside {ST_F5, ST_F8, ST_F7}) begin
                            st_d    = ST_F3_PEND;
                            cv_d    = 1'b1;
                            cc_d    = CMD_DEACT;
                            deact_d = (st_q == ST_F7);
                        end
                    end
                    IND_DEACT_F6: begin
                        if (st_q == ST_F6) begin
                            st_d = ST_F3_PEND;
                            cv_d = 1'b1;
                            cc_d = CMD_DEACT;
                        end
                    end
                    default: ;
                endcase
            end
            EV_ACT: begin
                if (st_q == ST_F3_PDN) begin
                    cv_d      = 1'b1;
                    cc_d      = CMD_ACT8;
                    tmr_start = 1'b1;
                end
            end
            EV_TMR: begin
                if (st_q inside {ST_F3_PDN, ST_F4, ST_F5, ST_F6, ST_F8}) begin
                    cv_d    = 1'b1;
                    cc_d    = CMD_DEACT;
                    deact_d = 1'b1;
                end
            end
            EV_DEACT, EV_NONE: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= CMD_TIMING;
            act_ind   <= 1'b0;
            deact_ind <= 1'b0;
        end else begin
            cmd_valid <= cv_d;
            if (cv_d) cmd_code <= cc_d;
            act_ind   <= act_d;
            deact_ind <= deact_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/l1_act_ctrl.sv
module l1_act_ctrl
    import l1_act_pkg::*;
#(
    parameter int TIMER_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ind_valid,
    input  logic [3:0] ind_code,
    input  logic       act_req,
    input  logic       deact_req,
    output logic       cmd_valid,
    output logic [3:0] cmd_code,
    output logic       act_ind,
    output logic       deact_ind,
    output logic [3:0] state_o
);
    l1_event_t ev;
    logic      tmr_expire, tmr_start, tmr_cancel;
    l1_state_e st;

    l1_event_arb u_arb (
        .ind_valid (ind_valid),
        .ind_code  (ind_code),
        .act_req   (act_req),
        .deact_req (deact_req),
        .tmr_expire(tmr_expire),
        .ev        (ev)
    );

    l1_sup_timer #(.RELOAD(TIMER_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .cancel(tmr_cancel),
        .expire(tmr_expire)
    );

    l1_act_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .tmr_start (tmr_start),
        .tmr_cancel(tmr_cancel),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .act_ind   (act_ind),
        .deact_ind (deact_ind),
        .state     (st)
    );

    assign state_o = st;
endmodule

// File: rtl/l1_act_ctrl_chk.sv
module l1_act_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_code,
    input logic       act_ind,
    input logic       deact_ind,
    input logic [3:0] state_o
);
    a_r3_act_means_f7: assert property (@(posedge clk) disable iff (!rst_n)
        act_ind |-> (state_o == 4'd7 && cmd_valid && cmd_code == 4'h8));

    a_r9_f7_exit_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_o) == 4'd7 && state_o != 4'd7) |-> deact_ind);

    a_r2_reset_entry_di: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd0 && $past(state_o) != 4'd0) |-> (cmd_valid && cmd_code == 4'hF));

    a_r6_f4_from_pdn: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 4'd4 && $past(state_o) != 4'd4) |-> $past(state_o) == 4'd1);

    a_r10_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code == 4'h8 || cmd_code == 4'hF));

    a_r10_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_ind && deact_ind));

    a_r10_act_single: assert property (@(posedge clk) disable iff (!rst_n)
        act_ind |=> !act_ind);

    a_r10_deact_single: assert property (@(posedge clk) disable iff (!rst_n)
        deact_ind |=> !deact_ind);

    a_r1_state_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 4'd8);
endmodule

bind l1_act_ctrl l1_act_ctrl_chk u_chk (.*);

// File: tb/l1_act_ctrl_tb.sv
module l1_act_ctrl_tb;
    localparam int TR = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ind_valid = 1'b0;
    logic [3:0] ind_code = 4'd0;
    logic       act_req = 1'b0;
    logic       deact_req = 1'b0;
    logic       cmd_valid, act_ind, deact_ind;
    logic [3:0] cmd_code, state_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_st = 0, m_cc = 0, m_left = 0;
    bit m_cv = 0, m_act = 0, m_deact = 0, m_run = 0;

    always #10 clk = ~clk;

    l1_act_ctrl #(.TIMER_CYCLES(TR)) u_dut (
        .clk(clk), .rst_n(rst_n), .ind_valid(ind_valid), .ind_code(ind_code),
        .act_req(act_req), .deact_req(deact_req), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .act_ind(act_ind), .deact_ind(deact_ind), .state_o(state_o)
    );

    function automatic bit in_set(int s, int mask);
        return ((mask >> s) & 1) == 1;
    endfunction

    task automatic give(int ns, bit cv, int cc, bit a, bit d);
        m_st = ns;
        if (cv) begin m_cv = 1; m_cc = cc; end
        m_act = a;
        m_deact = d;
    endtask

    task automatic model(bit iv, int ic, bit ar, bit dr);
        bit expd;
        bit start = 0, cancel = 0;
        int s = m_st;
        expd = m_run && (m_left == 1);
        m_cv = 0; m_act = 0; m_deact = 0;
        if (iv) begin
            if ((ic == 1 || ic == 6) && s != 2) give(0, 1, 15, 0, s == 7);
            else if (ic == 12 && s != 2 && s != 7) begin give(7, 1, 8, 1, 0); cancel = 1; end
            else if (ic == 15 && in_set(s, 9'b101111001)) give(1, 0, 0, 0, 0);
            else if (ic == 8 && in_set(s, 9'b100101011)) give(6, 0, 0, 0, 0);
            else if (ic == 8 && s == 7) give(6, 0, 0, 0, 1);
            else if (ic == 4 && in_set(s, 9'b000011010)) give(5, 0, 0, 0, 0);
            else if (ic == 4 && s == 6) give(8, 0, 0, 0, 0);
            else if (ic == 4 && s == 7) give(8, 0, 0, 0, 1);
            else if (ic == 7 && s == 1) give(4, 0, 0, 0, 0);
            else if (ic == 0 && (s == 5 || s == 8)) give(3, 1, 15, 0, 0);
            else if (ic == 0 && s == 7) give(3, 1, 15, 0, 1);
            else if (ic == 5 && s == 6) give(3, 1, 15, 0, 0);
        end else if (ar) begin
            if (s == 1) begin give(1, 1, 8, 0, 0); start = 1; end
        end else if (dr) begin
            // never acted upon
        end else if (expd) begin
            if (in_set(s, 9'b101110010)) give(s, 1, 15, 0, 1);
        end
        if (start) begin m_run = 1; m_left = TR; end
        else if (cancel) m_run = 0;
        else if (m_run) begin
            if (m_left == 1) m_run = 0;
            else m_left--;
        end
    endtask

    task automatic fail_line(string tag, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    // R12: every cycle compared with the model right after the edge
    task automatic compare_model();
        checks++;
        if (state_o != 4'(m_st)) fail_line("R12", "state", state_o, m_st);
        else if (cmd_valid != m_cv) fail_line("R12", "cmd_valid", cmd_valid, m_cv);
        else if (m_cv && cmd_code != 4'(m_cc)) fail_line("R12", "cmd_code", cmd_code, m_cc);
        else if (act_ind != m_act) fail_line("R12", "act_ind", act_ind, m_act);
        else if (deact_ind != m_deact) fail_line("R12", "deact_ind", deact_ind, m_deact);
    endtask

    task automatic step(bit iv, logic [3:0] ic, bit ar, bit dr);
        ind_valid = iv; ind_code = ic; act_req = ar; deact_req = dr;
        @(posedge clk);
        model(iv, int'(ic), ar, dr);
        #2;
        compare_model();
        ind_valid = 0; act_req = 0; deact_req = 0;
    endtask

    task automatic ind(logic [3:0] c);
        step(1, c, 0, 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 4'd0, 0, 0);
    endtask

    task automatic chk(string tag, int st, bit cv, int cc, bit a, bit d);
        checks++;
        if (state_o != 4'(st)) fail_line(tag, "state", state_o, st);
        else if (cmd_valid != cv) fail_line(tag, "cmd_valid", cmd_valid, cv);
        else if (cv && cmd_code != 4'(cc)) fail_line(tag, "cmd_code", cmd_code, cc);
        else if (act_ind != a) fail_line(tag, "act_ind", act_ind, a);
        else if (deact_ind != d) fail_line(tag, "deact_ind", deact_ind, d);
    endtask

    task automatic hw_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #2;
        m_st = 0; m_cv = 0; m_cc = 0; m_act = 0; m_deact = 0; m_run = 0; m_left = 0;
        chk("R1", 0, 0, 0, 0, 0);
        rst_n = 1;
    endtask

    initial begin
        bit seen;
        hw_reset();

        // R10: ignored inputs in reset
        ind(4'b0010); chk("R10", 0, 0, 0, 0, 0);
        step(0, 4'd0, 0, 1); chk("R10", 0, 0, 0, 0, 0);
        ind(4'b1001); chk("R10", 0, 0, 0, 0, 0);
        step(0, 4'd0, 1, 0); chk("R4", 0, 0, 0, 0, 0);

        // R6: power-down
        ind(4'b1111); chk("R6", 1, 0, 0, 0, 0);

        // R4/R5: request then supervision expiry after TR edges
        step(0, 4'd0, 1, 0); chk("R4", 1, 1, 8, 0, 0);
        seen = 0;
        for (int i = 0; i < TR - 1; i++) begin
            idle(1);
            if (deact_ind) seen = 1;
        end
        checks++;
        if (seen) fail_line("R5", "early expiry", 1, 0);
        idle(1); chk("R5", 1, 1, 15, 0, 1);
        idle(TR + 2); chk("R5", 1, 0, 0, 0, 0);

        // R6: power-up, activate request ignored in F4
        ind(4'b0111); chk("R6", 4, 0, 0, 0, 0);
        step(0, 4'd0, 1, 0); chk("R4", 4, 0, 0, 0, 0);

        // R7/R8 paths
        ind(4'b0100); chk("R7", 5, 0, 0, 0, 0);
        ind(4'b0000); chk("R8", 3, 1, 15, 0, 0);
        ind(4'b1000); chk("R7", 6, 0, 0, 0, 0);
        ind(4'b0101); chk("R8", 3, 1, 15, 0, 0);
        ind(4'b1000); ind(4'b0100); chk("R7", 8, 0, 0, 0, 0);
        ind(4'b0000); chk("R8", 3, 1, 15, 0, 0);

        // R3: activation and F7 exits (R9)
        ind(4'b1100); chk("R3", 7, 1, 8, 1, 0);
        ind(4'b1111); chk("R10", 7, 0, 0, 0, 0);
        ind(4'b0100); chk("R9", 8, 0, 0, 0, 1);
        ind(4'b1100); ind(4'b1000); chk("R9", 6, 0, 0, 0, 1);
        ind(4'b1100); ind(4'b0000); chk("R9", 3, 1, 15, 0, 1);
        ind(4'b1100); ind(4'b0001); chk("R2", 0, 1, 15, 0, 1);
        ind(4'b1111); ind(4'b0111); ind(4'b0110); chk("R2", 0, 1, 15, 0, 0);

        // R3: timer cancelled by reaching F7
        ind(4'b1111); step(0, 4'd0, 1, 0); idle(3);
        ind(4'b1100); chk("R3", 7, 1, 8, 1, 0);
        ind(4'b1000); chk("R9", 6, 0, 0, 0, 1);
        seen = 0;
        for (int i = 0; i < TR + 2; i++) begin
            idle(1);
            if (deact_ind || cmd_valid) seen = 1;
        end
        checks++;
        if (seen) fail_line("R3", "expiry after cancel", 1, 0);

        // R11: priority of colliding inputs
        ind(4'b1111);
        step(1, 4'b0111, 1, 0); chk("R11", 4, 0, 0, 0, 0);
        ind(4'b1111);
        step(1, 4'b0010, 1, 0); chk("R11", 1, 0, 0, 0, 0);
        step(0, 4'd0, 1, 1); chk("R11", 1, 1, 8, 0, 0);

        // R1: hardware reset from an active state
        ind(4'b1100);
        hw_reset();
        idle(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule